// File: doc/BRIEF.md
# Encrypted Region Control Registers

This block is the register file that sits in front of an inline DRAM encryption engine. Software reaches it over a simple 32-bit read/write bus. Through that bus it programs one address window (lower bound, upper bound, an enable bit and an encrypt/bypass select) and loads a write-only master key that goes straight to the cipher. It can also set two sticky lock bits and a privilege gate, and it reads fixed identification words. A status word reports whether the whole key has been loaded and whether the encryption function is fused off in hardware.

A second, independent port takes a DRAM address and answers, in the same cycle, whether that address is inside the enabled encrypted window or passes through in bypass.

Region bounds are kept at 64 KiB resolution: only address bits 31:16 are stored. The upper bound is inclusive of its whole 64 KiB block.

Top module: `enc_region_regs`

## Requirements
- R1: After reset every writable field is zero: control, privilege, region configuration, both bounds and the key. The key-valid flag is also zero.
- R2: Control bit 0 (global lock) and bit 1 (key lock) can be set by writing 1. Writing 0 never clears them; only reset does.
- R3: While the key lock is set, writes to key word offsets leave the key output and the key-valid flag unchanged.
- R4: Key words live at byte offset 0x200 + 4*i, and word i drives key output bits [32i+31:32i]. Status bit 0 (key valid) is 1 only once every key word has been written at least once since reset.
- R5: Status bit 4 reads the hardware encryption-disable input; every other status bit except bit 0 reads zero.
- R6: At offset 0x040, bit 0 is the region enable and bit 15 is the encrypt select. Both read back at the same positions.
- R7: The bounds at 0x044 (start) and 0x048 (end) store write-data bits 31:16. On read, bits 31:30 are zero, bits 29:16 hold the stored bits, and bits 15:0 are zero.
- R8: The lookup output is 1 only when enable and encrypt are both set and start:0x0000 <= address <= end:0xFFFF over the full 32 bits. Otherwise it is 0.
- R9: Offset 0x3F4 reads 0x10 (major revision 1 in bits 7:4, minor revision 0 in bits 3:0). Offset 0x3F8 reads 0x00A10031 and offset 0x3FC reads 0x5E1C0002.
- R10: When privilege bit 0 (offset 0x01C) is set, a bus access with the privileged flag low is ignored on write and returns zero on read.
- R11: While the global lock is set, writes to the region configuration, the bounds and the privilege register are ignored. A control write can still set the key lock.
- R12: Key offsets and unmapped offsets read as zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_priv_i | input | 1 | Access is privileged |
| bus_addr_i | input | 10 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| hw_enc_dis_i | input | 1 | Encryption function disabled in hardware |
| lookup_addr_i | input | 32 | DRAM address to classify |
| lookup_enc_o | output | 1 | Address is in the enabled encrypted window |
| key_o | output | 128 | Master key to the cipher |

## Verification
The lookup port is driven with a table of addresses: one block below the start, the exact start, a point inside, the last byte of the end block, the first byte past it, and an address whose low bits match but whose top bits do not. These separate off-by-one errors at each bound, a non-inclusive end, and a compare that drops the top two bits. The same address is then tried with only enable set and with only encrypt set, to separate an AND from an OR of the two. Bus traffic covers partial and complete key loads, each lock before and after it is set, and privileged against unprivileged accesses. This separates gating on the wrong lock or on the wrong access type.

// File: rtl/enc_regs_pkg.sv
package enc_regs_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_PRIV   = 10'h01C;
  localparam logic [ADDR_W-1:0] OFF_RCFG   = 10'h040;
  localparam logic [ADDR_W-1:0] OFF_RSTART = 10'h044;
  localparam logic [ADDR_W-1:0] OFF_REND   = 10'h048;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 10'h200;
  localparam logic [ADDR_W-1:0] OFF_VER    = 10'h3F4;
  localparam logic [ADDR_W-1:0] OFF_ID     = 10'h3F8;
  localparam logic [ADDR_W-1:0] OFF_SID    = 10'h3FC;

  typedef struct packed {
    logic        en;
    logic        enc;
    logic [15:0] lo;
    logic [15:0] hi;
  } region_t;
endpackage

// File: rtl/enc_key_store.sv
module enc_key_store #(
  parameter int unsigned KEY_WORDS = 4,
  localparam int unsigned IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    lock_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [31:0]             wdata_i,
  output logic [32*KEY_WORDS-1:0] key_o,
  output logic                    valid_o
);
  logic [KEY_WORDS-1:0] loaded_q;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_i && !lock_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_o[32*g +: 32] <= '0;
        loaded_q[g]       <= 1'b0;
      end else if (hit) begin
        key_o[32*g +: 32] <= wdata_i;
        loaded_q[g]       <= 1'b1;
      end
    end
  end

  assign valid_o = &loaded_q;
endmodule

// File: rtl/enc_region_match.sv
module enc_region_match
  import enc_regs_pkg::*;
(
  input  region_t     region_i,
  input  logic [31:0] addr_i,
  output logic        enc_o
);
  logic above_lo, below_hi;
  assign above_lo = addr_i >= {region_i.lo, 16'h0000};
  assign below_hi = addr_i <= {region_i.hi, 16'hFFFF};
  assign enc_o    = region_i.en && region_i.enc && above_lo && below_hi;
endmodule

// File: rtl/enc_region_regs.sv
module enc_region_regs
  import enc_regs_pkg::*;
#(
  parameter int unsigned KEY_BITS = 128,
  parameter logic [3:0]  VER_MAJOR = 4'h1,
  parameter logic [3:0]  VER_MINOR = 4'h0,
  parameter logic [31:0] ID_WORD   = 32'h00A1_0031,
  parameter logic [31:0] SID_WORD  = 32'h5E1C_0002,
  localparam int unsigned KEY_WORDS = KEY_BITS / 32,
  localparam int unsigned IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic                bus_priv_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                hw_enc_dis_i,
  input  logic [31:0]         lookup_addr_i,
  output logic                lookup_enc_o,
  output logic [KEY_BITS-1:0] key_o
);
  localparam logic [ADDR_W-1:0] KEY_SPAN = ADDR_W'(4 * KEY_WORDS);

  logic    glock_q, klock_q, priv_q, key_valid;
  region_t region_q;

  // privilege gate
  logic blocked, wr, rd;
  assign blocked = priv_q && !bus_priv_i;
  assign wr = bus_req_i && bus_we_i && !blocked;
  assign rd = bus_req_i && !bus_we_i && !blocked;

  logic [ADDR_W-1:0] key_off;
  logic              key_sel;
  assign key_off = bus_addr_i - OFF_KEY;
  assign key_sel = (key_off < KEY_SPAN) && (key_off[1:0] == 2'b00);

  logic wr_ctrl, wr_cfg;
  assign wr_ctrl = wr && (bus_addr_i == OFF_CTRL);
  assign wr_cfg  = wr && !glock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glock_q  <= 1'b0;
      klock_q  <= 1'b0;
      priv_q   <= 1'b0;
      region_q <= '0;
    end else begin
      if (wr_ctrl) begin
        glock_q <= glock_q | bus_wdata_i[0];
        klock_q <= klock_q | bus_wdata_i[1];
      end
      if (wr_cfg) begin
        unique case (bus_addr_i)
          OFF_PRIV:    priv_q <= bus_wdata_i[0];
          OFF_RCFG: begin
            region_q.en  <= bus_wdata_i[0];
            region_q.enc <= bus_wdata_i[15];
          end
          OFF_RSTART:  region_q.lo <= bus_wdata_i[31:16];
          OFF_REND:    region_q.hi <= bus_wdata_i[31:16];
          default: ;
        endcase
      end
    end
  end

  enc_key_store #(.KEY_WORDS(KEY_WORDS)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && key_sel),
    .lock_i  (klock_q),
    .idx_i   (key_off[IDX_W+1:2]),
    .wdata_i (bus_wdata_i),
    .key_o   (key_o),
    .valid_o (key_valid)
  );

  enc_region_match u_match (
    .region_i (region_q),
    .addr_i   (lookup_addr_i),
    .enc_o    (lookup_enc_o)
  );

  // bounds read back without bits 31:30
  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        OFF_CTRL:   bus_rdata_o = {30'b0, klock_q, glock_q};
        OFF_STAT:   bus_rdata_o = {27'b0, hw_enc_dis_i, 3'b0, key_valid};
        OFF_PRIV:   bus_rdata_o = {31'b0, priv_q};
        OFF_RCFG:   bus_rdata_o = {16'b0, region_q.enc, 14'b0, region_q.en};
        OFF_RSTART: bus_rdata_o = {2'b0, region_q.lo[13:0], 16'b0};
        OFF_REND:   bus_rdata_o = {2'b0, region_q.hi[13:0], 16'b0};
        OFF_VER:    bus_rdata_o = {24'b0, VER_MAJOR, VER_MINOR};
        OFF_ID:     bus_rdata_o = ID_WORD;
        OFF_SID:    bus_rdata_o = SID_WORD;
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/enc_region_regs_chk.sv
module enc_region_regs_chk
  import enc_regs_pkg::*;
#(
  parameter int unsigned KEY_BITS = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_req_i,
  input logic                bus_we_i,
  input logic                bus_priv_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic                lookup_enc_o,
  input logic [KEY_BITS-1:0] key_o,
  input logic                glock_q,
  input logic                klock_q,
  input logic                priv_q,
  input logic                key_valid,
  input region_t             region_q
);
  a_r2_glock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glock_q |=> glock_q);
  a_r2_klock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    klock_q |=> klock_q);
  a_r3_key_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    klock_q |=> $stable(key_o));
  a_r4_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid |=> key_valid);
  a_r8_off_is_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(region_q.en && region_q.enc) |-> !lookup_enc_o);
  a_r10_unpriv_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && priv_q && !bus_priv_i) |-> (bus_rdata_o == '0));
  a_r11_region_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glock_q |=> ($stable(region_q) && $stable(priv_q)));
endmodule

bind enc_region_regs enc_region_regs_chk #(.KEY_BITS(KEY_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_priv_i   (bus_priv_i),
  .bus_rdata_o  (bus_rdata_o),
  .lookup_enc_o (lookup_enc_o),
  .key_o        (key_o),
  .glock_q      (glock_q),
  .klock_q      (klock_q),
  .priv_q       (priv_q),
  .key_valid    (key_valid),
  .region_q     (region_q)
);

// File: tb/enc_region_regs_tb_top.sv
`timescale 1ns/1ps
module enc_region_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0, priv = 1'b1;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         hw_dis = 1'b0;
  logic [31:0]  lk_addr = '0;
  logic         lk_enc;
  logic [127:0] key;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  enc_region_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_priv_i(priv), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .hw_enc_dis_i(hw_dis), .lookup_addr_i(lk_addr),
    .lookup_enc_o(lk_enc), .key_o(key)
  );

  // {address, expected lookup}
  localparam logic [32:0] LK_TAB [6] = '{
    {32'h800F_FFFF, 1'b0}, {32'h8010_0000, 1'b1}, {32'h8015_1234, 1'b1},
    {32'h801F_FFFF, 1'b1}, {32'h8020_0000, 1'b0}, {32'h0015_0000, 1'b0}
  };

  task automatic check(string req_tag, logic [127:0] got, logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req_tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [31:0] d, logic p = 1'b1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    req = 1'b0; we = 1'b0; priv = 1'b1;
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [31:0] d, input logic p = 1'b1);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; priv = p;
    #1 d = rdata;
    req = 1'b0; priv = 1'b1;
  endtask

  task automatic expect_rd(string tag, logic [9:0] a, logic [31:0] exp, logic p = 1'b1);
    logic [31:0] d;
    bus_rd(a, d, p);
    check(tag, {96'b0, d}, {96'b0, exp});
  endtask

  task automatic expect_lk(string tag, logic [31:0] a, logic exp);
    @(negedge clk);
    lk_addr = a;
    #1 check(tag, {127'b0, lk_enc}, {127'b0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 / R9: reset values and constants
    expect_rd("R1 ctrl", 10'h000, 32'h0);
    expect_rd("R1 status", 10'h004, 32'h0);
    expect_rd("R1 rcfg", 10'h040, 32'h0);
    expect_rd("R1 start", 10'h044, 32'h0);
    check("R1 key", key, 128'h0);
    expect_rd("R9 version", 10'h3F4, 32'h10);
    expect_rd("R9 id", 10'h3F8, 32'h00A1_0031);
    expect_rd("R9 sid", 10'h3FC, 32'h5E1C_0002);

    // R5
    hw_dis = 1'b1;
    expect_rd("R5 dis set", 10'h004, 32'h10);
    hw_dis = 1'b0;
    expect_rd("R5 dis clear", 10'h004, 32'h0);

    // R6 / R7 region programming
    bus_wr(10'h044, 32'h8010_ABCD);
    bus_wr(10'h048, 32'h801F_0000);
    bus_wr(10'h040, 32'h0000_8001);
    expect_rd("R6 rcfg", 10'h040, 32'h0000_8001);
    expect_rd("R7 start", 10'h044, 32'h0010_0000);
    expect_rd("R7 end", 10'h048, 32'h001F_0000);

    // R8 table walk
    foreach (LK_TAB[i]) expect_lk("R8 table", LK_TAB[i][32:1], LK_TAB[i][0]);
    bus_wr(10'h040, 32'h0000_8000);
    expect_lk("R8 enc only", 32'h8015_0000, 1'b0);
    bus_wr(10'h040, 32'h0000_0001);
    expect_lk("R8 en only", 32'h8015_0000, 1'b0);
    bus_wr(10'h040, 32'h0000_8001);
    expect_lk("R8 restored", 32'h8015_0000, 1'b1);

    // R4 key load
    bus_wr(10'h200, 32'h1111_0000);
    bus_wr(10'h204, 32'h2222_0001);
    bus_wr(10'h208, 32'h3333_0002);
    expect_rd("R4 partial", 10'h004, 32'h0);
    bus_wr(10'h20C, 32'h4444_0003);
    expect_rd("R4 full", 10'h004, 32'h1);
    check("R4 key value", key, 128'h4444_0003_3333_0002_2222_0001_1111_0000);

    // R12
    expect_rd("R12 key read", 10'h200, 32'h0);
    bus_wr(10'h100, 32'hFFFF_FFFF);
    expect_rd("R12 unmapped", 10'h100, 32'h0);
    expect_rd("R12 rcfg kept", 10'h040, 32'h0000_8001);

    // R10 privilege
    bus_wr(10'h01C, 32'h1);
    bus_wr(10'h040, 32'h0, 1'b0);
    expect_rd("R10 write ignored", 10'h040, 32'h0000_8001);
    expect_rd("R10 read zero", 10'h3F4, 32'h0, 1'b0);
    expect_rd("R10 priv read", 10'h3F4, 32'h10);

    // R3 / R2 key lock
    bus_wr(10'h000, 32'h2);
    bus_wr(10'h200, 32'hDEAD_BEEF);
    check("R3 key frozen", key, 128'h4444_0003_3333_0002_2222_0001_1111_0000);
    bus_wr(10'h000, 32'h0);
    expect_rd("R2 klock sticky", 10'h000, 32'h2);

    // R11 / R2 global lock
    bus_wr(10'h000, 32'h1);
    expect_rd("R2 both locks", 10'h000, 32'h3);
    bus_wr(10'h040, 32'h0);
    bus_wr(10'h044, 32'h0);
    bus_wr(10'h01C, 32'h0);
    expect_rd("R11 rcfg frozen", 10'h040, 32'h0000_8001);
    expect_rd("R11 start frozen", 10'h044, 32'h0010_0000);
    expect_rd("R11 priv frozen", 10'h01C, 32'h0, 1'b0);
    bus_wr(10'h000, 32'h0);
    expect_rd("R2 glock sticky", 10'h000, 32'h3);

    // R11 key lock settable under global lock; R1 after second reset
    do_reset();
    expect_rd("R1 status again", 10'h004, 32'h0);
    check("R1 key again", key, 128'h0);
    bus_wr(10'h000, 32'h1);
    bus_wr(10'h000, 32'h2);
    expect_rd("R11 klock under glock", 10'h000, 32'h3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule